// File: doc/BRIEF.md
# Associative Frame-Table Address Translator

This block turns a virtual address into a physical address by keeping one slot per physical page frame. Each slot holds the virtual page number that currently occupies its frame. An incoming virtual page number is compared against every slot at once. The position of the slot that matches becomes the physical frame number. Because no slot stores a frame number, a table with one entry per frame is enough, however large the virtual space. When nothing matches, the block reports a page fault instead of an address.

Software keeps the table current through a load port. The port writes a page number into a chosen frame, or invalidates that frame. Every slot tracks whether its frame has been referenced and whether it has been written. A replacement routine can read those two flags through a small peek port when it picks a victim. Lookups are pipelined, so one request per cycle is accepted and each result appears on the following cycle.

Top module: `frame_xlate`

## Requirements
- R1: After reset every slot is invalid, both flags of every frame read 0, `rsp_valid` is 0, and any lookup faults.
- R2: A request accepted on one clock edge produces `rsp_valid`=1 on the next edge. On a hit, the upper bits of `rsp_paddr` (bits PA_W-1 down to OFFS_W) carry the index of the matching slot.
- R3: The low OFFS_W bits of `rsp_paddr` equal the low OFFS_W bits of the request address, unchanged, on every hit.
- R4: When no valid slot holds the requested page number, `rsp_fault`=1, `rsp_multi`=0 and `rsp_paddr`=0.
- R5: A slot that has been invalidated, or that has never been loaded, never matches.
- R6: When several valid slots hold the requested page, the lowest slot index is returned and `rsp_multi`=1. `rsp_fault` is 0 in that case.
- R7: A read hit (`req_write`=0) sets the used flag of the returned frame and leaves its modified flag unchanged.
- R8: A write hit (`req_write`=1) sets both the used flag and the modified flag of the returned frame.
- R9: A load with `ld_inval`=0 stores `ld_vpn` in frame `ld_frame`, marks it valid and clears both of its flags. A load with `ld_inval`=1 marks the frame invalid.
- R10: When a load and a lookup fall on the same edge, the lookup sees the table as it was before the load. If both touch the same frame, the load's cleared flags win.
- R11: On a cycle after no request was accepted, `rsp_valid`, `rsp_fault` and `rsp_multi` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request accepted on this edge |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_write | input | 1 | Request is a write access |
| rsp_valid | output | 1 | Result of the previous cycle's request |
| rsp_fault | output | 1 | No slot matched (page fault) |
| rsp_multi | output | 1 | More than one slot matched |
| rsp_paddr | output | FN_W+OFFS_W | Physical address: frame index, then offset |
| ld_en | input | 1 | Load port strobe |
| ld_inval | input | 1 | Invalidate the frame instead of loading it |
| ld_frame | input | FN_W | Frame index to load or invalidate |
| ld_vpn | input | VA_W-OFFS_W | Virtual page number to store |
| peek_frame | input | FN_W | Frame whose flags are shown |
| peek_used | output | 1 | Used flag of `peek_frame` |
| peek_mod | output | 1 | Modified flag of `peek_frame` |

## Verification
The load port and the lookup path can act on the same edge, and even on the same frame. The bench provokes this by driving a load that replaces the page in frame 9 together with a write lookup of the old page in that frame. The returned address must be the pre-load translation. The peek port must then show both flags of frame 9 cleared, because the load overrides the hit. A follow-up lookup of the new page must hit frame 9, and a lookup of the old page must now fault.

// File: rtl/frame_xlate_pkg.sv
package frame_xlate_pkg;
  localparam int unsigned DEF_VA_W   = 32;
  localparam int unsigned DEF_OFFS_W = 12;
  localparam int unsigned DEF_FRAMES = 16;

  typedef struct packed {
    logic used;
    logic mod;
  } frame_flags_t;
endpackage

// File: rtl/frame_slot.sv
module frame_slot
  import frame_xlate_pkg::*;
#(
  parameter int unsigned VPN_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_sel,
  input  logic             ld_inval,
  input  logic [VPN_W-1:0] ld_vpn,
  input  logic [VPN_W-1:0] look_vpn,
  input  logic             touch,
  input  logic             touch_wr,
  output logic             match,
  output frame_flags_t     flags
);
  logic [VPN_W-1:0] vpn_q;
  logic             valid_q;

  assign match = valid_q && (vpn_q == look_vpn);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      flags   <= '0;
      vpn_q   <= '0;
    end else if (ld_sel) begin
      vpn_q   <= ld_vpn;
      valid_q <= !ld_inval;
      flags   <= '0;
    end else if (touch) begin
      flags.used <= 1'b1;
      if (touch_wr) flags.mod <= 1'b1;
    end
  end
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int unsigned N = 16,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any,
  output logic          multi
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

  assign any   = |vec;
  assign multi = (vec & (vec - N'(1))) != '0;
endmodule

// File: rtl/frame_xlate.sv
module frame_xlate
  import frame_xlate_pkg::*;
#(
  parameter int unsigned VA_W   = DEF_VA_W,
  parameter int unsigned OFFS_W = DEF_OFFS_W,
  parameter int unsigned FRAMES = DEF_FRAMES,
  localparam int unsigned VPN_W = VA_W - OFFS_W,
  localparam int unsigned FN_W  = (FRAMES > 1) ? $clog2(FRAMES) : 1,
  localparam int unsigned PA_W  = FN_W + OFFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic              rsp_multi,
  output logic [PA_W-1:0]   rsp_paddr,
  input  logic              ld_en,
  input  logic              ld_inval,
  input  logic [FN_W-1:0]   ld_frame,
  input  logic [VPN_W-1:0]  ld_vpn,
  input  logic [FN_W-1:0]   peek_frame,
  output logic              peek_used,
  output logic              peek_mod
);
  logic [VPN_W-1:0]  look_vpn;
  logic [OFFS_W-1:0] look_off;
  logic [FRAMES-1:0] match_vec;
  frame_flags_t      flag_arr [FRAMES];
  logic [FN_W-1:0]   win_idx;
  logic              any_hit;
  logic              many_hit;

  assign look_vpn = req_vaddr[VA_W-1:OFFS_W];
  assign look_off = req_vaddr[OFFS_W-1:0];

  for (genvar g = 0; g < FRAMES; g++) begin : g_slot
    frame_slot #(.VPN_W(VPN_W)) slot_i (
      .clk      (clk),
      .rst      (rst),
      .ld_sel   (ld_en && (ld_frame == FN_W'(g))),
      .ld_inval (ld_inval),
      .ld_vpn   (ld_vpn),
      .look_vpn (look_vpn),
      .touch    (req_valid && any_hit && (win_idx == FN_W'(g))),
      .touch_wr (req_write),
      .match    (match_vec[g]),
      .flags    (flag_arr[g])
    );
  end

  prio_pick #(.N(FRAMES)) pick_i (
    .vec   (match_vec),
    .idx   (win_idx),
    .any   (any_hit),
    .multi (many_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_multi <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid && !any_hit;
      rsp_multi <= req_valid && many_hit;
      rsp_paddr <= (req_valid && any_hit) ? {win_idx, look_off} : '0;
    end
  end

  always_comb begin
    peek_used = 1'b0;
    peek_mod  = 1'b0;
    if (32'(peek_frame) < FRAMES) begin
      peek_used = flag_arr[peek_frame].used;
      peek_mod  = flag_arr[peek_frame].mod;
    end
  end
endmodule

// File: rtl/frame_xlate_chk.sv
module frame_xlate_chk #(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned OFFS_W = 12,
  parameter int unsigned PA_W   = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic [VA_W-1:0] req_vaddr,
  input logic            rsp_valid,
  input logic            rsp_fault,
  input logic            rsp_multi,
  input logic [PA_W-1:0] rsp_paddr
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !rsp_fault && !rsp_multi)); // R11
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault) |-> rsp_paddr[OFFS_W-1:0] == $past(req_vaddr[OFFS_W-1:0])); // R3
  AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (rsp_valid && !rsp_multi && rsp_paddr == '0)); // R4
  AST_MULTI_IS_HIT: assert property (@(posedge clk) disable iff (rst)
    rsp_multi |-> (rsp_valid && !rsp_fault)); // R6
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    $countones({rsp_fault, rsp_multi}) <= 1); // R4
endmodule

bind frame_xlate frame_xlate_chk #(.VA_W(VA_W), .OFFS_W(OFFS_W), .PA_W(PA_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_vaddr (req_vaddr),
  .rsp_valid (rsp_valid),
  .rsp_fault (rsp_fault),
  .rsp_multi (rsp_multi),
  .rsp_paddr (rsp_paddr)
);

// File: tb/frame_xlate_tb_top.sv
`timescale 1ns/1ps
module frame_xlate_tb_top;
  localparam int VA_W = 32, OFFS_W = 12, FRAMES = 16;
  localparam int VPN_W = VA_W - OFFS_W, FN_W = 4, PA_W = FN_W + OFFS_W;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_write = 0;
  logic [VA_W-1:0] req_vaddr = '0;
  logic rsp_valid, rsp_fault, rsp_multi;
  logic [PA_W-1:0] rsp_paddr;
  logic ld_en = 0, ld_inval = 0;
  logic [FN_W-1:0] ld_frame = '0, peek_frame = '0;
  logic [VPN_W-1:0] ld_vpn = '0;
  logic peek_used, peek_mod;

  always #2 clk = ~clk;

  frame_xlate dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_multi(rsp_multi), .rsp_paddr(rsp_paddr), .ld_en(ld_en),
    .ld_inval(ld_inval), .ld_frame(ld_frame), .ld_vpn(ld_vpn),
    .peek_frame(peek_frame), .peek_used(peek_used), .peek_mod(peek_mod));

  int checks = 0, fails = 0;
  bit finished = 0;

  // bench-side table model
  logic [VPN_W-1:0] m_vpn [FRAMES];
  bit m_val [FRAMES], m_used [FRAMES], m_mod [FRAMES];

  typedef struct packed { logic fault; logic multi; logic [PA_W-1:0] pa; } exp_t;
  exp_t exp_q[$];
  string tag_q[$];

  task automatic check(bit ok, string tag, string act, string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a response is present
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R2", "unexpected rsp", "none");
      end else begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({rsp_fault, rsp_multi, rsp_paddr} == e, t,
              $sformatf("f%0d m%0d pa=%h", rsp_fault, rsp_multi, rsp_paddr),
              $sformatf("f%0d m%0d pa=%h", e.fault, e.multi, e.pa));
      end
    end
  end

  // driver: lookup (optionally with a load on the same edge)
  task automatic lookup(logic [VA_W-1:0] va, bit wr, string tag,
                        bit with_ld = 0, int lf = 0, logic [VPN_W-1:0] lv = '0);
    exp_t e;
    int hit;
    int nh;
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_write = wr;
    ld_en = with_ld; ld_inval = 0; ld_frame = FN_W'(lf); ld_vpn = lv;
    hit = -1; nh = 0;
    for (int i = 0; i < FRAMES; i++)
      if (m_val[i] && m_vpn[i] == va[VA_W-1:OFFS_W]) begin
        nh++;
        if (hit < 0) hit = i;
      end
    e.fault = (hit < 0);
    e.multi = (nh > 1);
    e.pa = (hit < 0) ? '0 : {FN_W'(hit), va[OFFS_W-1:0]};
    exp_q.push_back(e);
    tag_q.push_back(tag);
    if (hit >= 0) begin
      m_used[hit] = 1;
      if (wr) m_mod[hit] = 1;
    end
    if (with_ld) begin
      m_vpn[lf] = lv; m_val[lf] = 1; m_used[lf] = 0; m_mod[lf] = 0;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 0; ld_en = 0;
  endtask

  task automatic load(int f, logic [VPN_W-1:0] v, bit inval);
    @(negedge clk);
    req_valid = 0;
    ld_en = 1; ld_inval = inval; ld_frame = FN_W'(f); ld_vpn = v;
    m_vpn[f] = v; m_val[f] = !inval; m_used[f] = 0; m_mod[f] = 0;
    @(negedge clk);
    ld_en = 0; ld_inval = 0;
  endtask

  task automatic chk_flags(int f, string tag);
    peek_frame = FN_W'(f);
    #1;
    check(peek_used == m_used[f] && peek_mod == m_mod[f], tag,
          $sformatf("u%0d m%0d", peek_used, peek_mod),
          $sformatf("u%0d m%0d", m_used[f], m_mod[f]));
  endtask

  task automatic chk_quiet(string tag);
    @(negedge clk);
    #0.5;
    check(!rsp_valid && !rsp_fault && !rsp_multi, tag,
          $sformatf("v%0d f%0d m%0d", rsp_valid, rsp_fault, rsp_multi), "v0 f0 m0");
  endtask

  initial begin
    for (int i = 0; i < FRAMES; i++) begin
      m_vpn[i] = '0; m_val[i] = 0; m_used[i] = 0; m_mod[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    #0.5;
    check(!rsp_valid, "R1", $sformatf("v%0d", rsp_valid), "v0");
    chk_flags(0, "R1");
    lookup(32'h0000_0123, 0, "R1");
    idle();
    // populate
    load(5, 20'h12345, 0);
    load(9, 20'hABCDE, 0);
    load(0, 20'h00001, 0);
    lookup(32'h1234_5ABC, 0, "R2");
    idle();
    chk_flags(5, "R7");
    lookup(32'hABCD_EFFF, 1, "R8");
    idle();
    chk_flags(9, "R8");
    // back-to-back lookups, offsets at both ends
    lookup(32'h0000_1000, 0, "R3");
    lookup(32'h0000_1FFF, 0, "R3");
    lookup(32'h7777_7123, 0, "R4");
    idle();
    chk_flags(0, "R7");
    chk_quiet("R11");
    // duplicate page: lowest index wins
    load(3, 20'h12345, 0);
    lookup(32'h1234_5010, 0, "R6");
    idle();
    chk_flags(3, "R6");
    // invalidate the duplicate
    load(3, 20'h12345, 1);
    lookup(32'h1234_5010, 0, "R5");
    idle();
    // reload frame 5: flags cleared, old page gone
    load(5, 20'h22222, 0);
    chk_flags(5, "R9");
    lookup(32'h1234_5010, 0, "R9");
    lookup(32'h2222_2777, 0, "R9");
    idle();
    // load and lookup on the same edge, same frame
    lookup(32'hABCD_E004, 1, "R10", 1, 9, 20'h33333);
    idle();
    chk_flags(9, "R10");
    lookup(32'h3333_3004, 0, "R10");
    lookup(32'hABCD_E004, 0, "R10");
    idle();
    // top frame index
    load(15, 20'hFFFFF, 0);
    lookup(32'hFFFF_FFFF, 0, "R2");
    idle();
    chk_quiet("R11");
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R2", $sformatf("%0d pending", exp_q.size()), "0 pending");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule